// File: doc/BRIEF.md
# Synchronized Double-Buffered Control Register Bank

This block keeps a small bank of control registers behind an equal number of staging buffers. A host loads the staging buffers through a parallel write port (enable, address, data) whenever it likes. Nothing it writes reaches the active registers until an update is requested. The whole block runs on the core clock. It divides that clock by four to make a synchronization clock and drives it on an output, so that external logic can line its own signals up with it.

An external update strobe is sampled only on the core cycle where the synchronization clock rises. A low-to-high change seen between two such samples becomes a single core-cycle transfer pulse in the following core cycle. At the end of that cycle every staging buffer is copied into its active register at once. The latency from the sampling edge to the copy is therefore the same for every update. A two-bit profile select and an output-shaping enable are also captured on the synchronization clock before they are passed on.

Top module: `sync_reg_update`

## Requirements
- R1: `syncClk` is 0 for two core cycles and 1 for two core cycles, repeating, so it rises exactly once every four core cycles.
- R2: `updStrobe` is looked at only on the core edge where `syncClk` rises. A strobe pulse that starts and ends between two such edges causes no transfer.
- R3: A sampled strobe value of 1 that follows a sampled value of 0 gives exactly one `xferPulse`, one core cycle wide. The pulse is high in the core cycle that follows the rising edge of `syncClk`. The active registers take the new values at the end of that cycle.
- R4: A strobe held high across any number of sampling edges produces only one transfer.
- R5: After the strobe has been sampled low at least once, a later sampled high produces a new transfer.
- R6: Staging writes do not change `activeRegs` outside a transfer. A transfer updates all four registers together. Register n occupies bits [32n+31:32n] of `activeRegs`.
- R7: A write with `wrAddr` greater than 3 changes no staging buffer, so no active register changes on a later transfer.
- R8: If a staging write lands in the same core cycle as `xferPulse`, the active register takes the buffer value from before that write. The new value moves only on a later transfer.
- R9: `profSel` and `shapeEn` are captured on the rising edge of `syncClk`. The outputs `profSelOut` and `shapeEnOut` change only then.
- R10: While `rst` is high, `syncClk`, `xferPulse`, `activeRegs`, `profSelOut` and `shapeEnOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Staging write enable |
| wrAddr | input | 3 | Staging buffer address; values 4 to 7 are ignored |
| wrData | input | 32 | Staging write data |
| updStrobe | input | 1 | Update request, sampled on the synchronization clock |
| profSel | input | 2 | Profile select, sampled on the synchronization clock |
| shapeEn | input | 1 | Output-shaping enable, sampled on the synchronization clock |
| syncClk | output | 1 | Core clock divided by four |
| xferPulse | output | 1 | One-cycle transfer pulse |
| activeRegs | output | 128 | Active register bank, flattened |
| profSelOut | output | 2 | Registered profile select |
| shapeEnOut | output | 1 | Registered shaping enable |

## Verification
If the divider phase is wrong, the transfer pulse shows up at the wrong offset from the rise of `syncClk`, or the rises are not four cycles apart. The bench sees this in the first synchronization period. A stuck or stale edge-detector state shows up in the next sampling period: the block gives either a second transfer for a held strobe or none for a fresh one. A staging buffer hit by the wrong address, or an active register loaded from a value taken too late, changes `activeRegs` at the next transfer. That is at most one core cycle after the pulse.

// File: rtl/sync_reg_pkg.sv
package sync_reg_pkg;
  typedef struct packed {
    logic xfer;   // copy staging into active
  } ctrlStrobes_t;
endpackage

// File: rtl/sync_reg_ctrl.sv
module sync_reg_ctrl
  import sync_reg_pkg::*;
#(
  parameter int DIV_W = 2,
  parameter int PROF_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              updStrobe,
  input  logic [PROF_W-1:0] profSel,
  input  logic              shapeEn,
  output logic              syncClk,
  output ctrlStrobes_t      strobes,
  output logic [PROF_W-1:0] profSelOut,
  output logic              shapeEnOut
);
  localparam logic [DIV_W-1:0] SAMPLE_PHASE = DIV_W'((1 << (DIV_W - 1)) - 1);
  localparam logic [DIV_W-1:0] XFER_PHASE   = DIV_W'(1 << (DIV_W - 1));

  logic [DIV_W-1:0] divCnt;
  logic             sampleEn;
  logic             stbNow;
  logic             stbPrev;

  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else     divCnt <= divCnt + 1'b1;
  end

  assign syncClk  = divCnt[DIV_W-1];
  assign sampleEn = (divCnt == SAMPLE_PHASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      stbNow     <= 1'b0;
      stbPrev    <= 1'b0;
      profSelOut <= '0;
      shapeEnOut <= 1'b0;
    end else if (sampleEn) begin
      stbNow     <= updStrobe;
      stbPrev    <= stbNow;
      profSelOut <= profSel;
      shapeEnOut <= shapeEn;
    end
  end

  always_comb begin
    strobes      = '0;
    strobes.xfer = !rst && (divCnt == XFER_PHASE) && stbNow && !stbPrev;
  end

  AST_SYNC_HIGH_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(syncClk) |=> syncClk); // R1
  AST_XFER_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    strobes.xfer |-> (syncClk && !$past(syncClk))); // R3
  AST_XFER_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    strobes.xfer |=> !strobes.xfer); // R3
  AST_PINS_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> ($stable(profSelOut) && $stable(shapeEnOut))); // R9
endmodule

// File: rtl/sync_reg_datapath.sv
module sync_reg_datapath
  import sync_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 4,
  parameter int ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctrlStrobes_t                 strobes,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  output logic [NUM_REGS*DATA_W-1:0]   activeRegs
);
  logic [DATA_W-1:0] stage [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    logic hitThis;
    assign hitThis = wrEn && (wrAddr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst)          stage[i] <= '0;
      else if (hitThis) stage[i] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (rst)               activeRegs[i*DATA_W +: DATA_W] <= '0;
      else if (strobes.xfer) activeRegs[i*DATA_W +: DATA_W] <= stage[i];
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.xfer |=> $stable(activeRegs)); // R6
endmodule

// File: rtl/sync_reg_update.sv
module sync_reg_update
  import sync_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 4,
  parameter int ADDR_W = 3,
  parameter int PROF_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       updStrobe,
  input  logic [PROF_W-1:0]          profSel,
  input  logic                       shapeEn,
  output logic                       syncClk,
  output logic                       xferPulse,
  output logic [NUM_REGS*DATA_W-1:0] activeRegs,
  output logic [PROF_W-1:0]          profSelOut,
  output logic                       shapeEnOut
);
  ctrlStrobes_t strobes;

  sync_reg_ctrl #(.DIV_W(2), .PROF_W(PROF_W)) ctrl_i (
    .clk(clk), .rst(rst), .updStrobe(updStrobe), .profSel(profSel),
    .shapeEn(shapeEn), .syncClk(syncClk), .strobes(strobes),
    .profSelOut(profSelOut), .shapeEnOut(shapeEnOut)
  );

  sync_reg_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .activeRegs(activeRegs)
  );

  assign xferPulse = strobes.xfer;
endmodule

// File: tb/sync_reg_update_tb.sv
module sync_reg_update_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic         updStrobe = 1'b0;
  logic [1:0]   profSel = '0;
  logic         shapeEn = 1'b0;
  logic         syncClk, xferPulse, shapeEnOut;
  logic [127:0] activeRegs;
  logic [1:0]   profSelOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] stageM [4];
  logic [31:0] actM [4];

  // addr(3) data(32) update(1)
  localparam logic [35:0] VEC [8] = '{
    {3'd0, 32'h1111_0000, 1'b0},
    {3'd1, 32'hA5A5_5A5A, 1'b0},
    {3'd2, 32'hDEAD_BEEF, 1'b0},
    {3'd3, 32'h0BAD_F00D, 1'b1},
    {3'd5, 32'hFFFF_FFFF, 1'b1},
    {3'd0, 32'h1234_5678, 1'b0},
    {3'd7, 32'h0000_0001, 1'b0},
    {3'd2, 32'h8000_0001, 1'b1}
  };

  sync_reg_update dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .updStrobe(updStrobe), .profSel(profSel), .shapeEn(shapeEn),
    .syncClk(syncClk), .xferPulse(xferPulse), .activeRegs(activeRegs),
    .profSelOut(profSelOut), .shapeEnOut(shapeEnOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] packM();
    return {actM[3], actM[2], actM[1], actM[0]};
  endfunction

  // returns at the negedge of the core cycle right after syncClk rose
  task automatic waitRise();
    logic prev = syncClk;
    forever begin
      @(negedge clk);
      if (syncClk && !prev) break;
      prev = syncClk;
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a < 3'd4) stageM[a[1:0]] = d;
  endtask

  task automatic runUpdate(input string req);
    updStrobe = 1'b1;
    waitRise();
    check("R3", {127'd0, xferPulse}, 128'd1);
    check("R6", activeRegs, packM());
    @(negedge clk);
    for (int k = 0; k < 4; k++) actM[k] = stageM[k];
    check(req, activeRegs, packM());
    check("R3", {127'd0, xferPulse}, 128'd0);
    updStrobe = 1'b0;
    waitRise();
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin stageM[k] = '0; actM[k] = '0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {124'd0, syncClk, xferPulse, profSelOut, shapeEnOut}, 128'd0);
    check("R10", activeRegs, 128'd0);
    rst = 1'b0;

    // R1: divided clock shape
    waitRise();
    check("R1", {127'd0, syncClk}, 128'd1);
    @(negedge clk); check("R1", {127'd0, syncClk}, 128'd1);
    @(negedge clk); check("R1", {127'd0, syncClk}, 128'd0);
    @(negedge clk); check("R1", {127'd0, syncClk}, 128'd0);
    @(negedge clk); check("R1", {127'd0, syncClk}, 128'd1);

    // vector table walk: R6 and R7
    for (int v = 0; v < 8; v++) begin
      hostWrite(VEC[v][35:33], VEC[v][32:1]);
      check("R6", activeRegs, packM());
      if (VEC[v][0]) runUpdate(VEC[v][35:33] > 3'd3 ? "R7" : "R6");
    end

    // R2: short strobe between sampling edges is missed
    hostWrite(3'd1, 32'h5555_AAAA);
    waitRise();
    @(negedge clk); updStrobe = 1'b1;
    @(negedge clk); updStrobe = 1'b0;
    waitRise();
    check("R2", {127'd0, xferPulse}, 128'd0);
    @(negedge clk);
    check("R2", activeRegs, packM());

    // R4 / R5: held strobe gives one transfer; low period re-arms
    updStrobe = 1'b1;
    waitRise();
    check("R4", {127'd0, xferPulse}, 128'd1);
    @(negedge clk);
    for (int k = 0; k < 4; k++) actM[k] = stageM[k];
    check("R4", activeRegs, packM());
    hostWrite(3'd0, 32'hCAFE_0001);
    waitRise();
    check("R4", {127'd0, xferPulse}, 128'd0);
    waitRise();
    check("R4", {127'd0, xferPulse}, 128'd0);
    @(negedge clk);
    check("R4", activeRegs, packM());
    updStrobe = 1'b0;
    waitRise();
    updStrobe = 1'b1;
    waitRise();
    check("R5", {127'd0, xferPulse}, 128'd1);
    @(negedge clk);
    for (int k = 0; k < 4; k++) actM[k] = stageM[k];
    check("R5", activeRegs, packM());
    updStrobe = 1'b0;
    waitRise();

    // R8: write in the transfer cycle
    hostWrite(3'd3, 32'h0000_00AA);
    updStrobe = 1'b1;
    waitRise();
    check("R8", {127'd0, xferPulse}, 128'd1);
    wrEn = 1'b1; wrAddr = 3'd3; wrData = 32'h0000_00BB;
    @(negedge clk);
    wrEn = 1'b0;
    for (int k = 0; k < 4; k++) actM[k] = stageM[k];
    stageM[3] = 32'h0000_00BB;
    check("R8", activeRegs, packM());
    updStrobe = 1'b0;
    waitRise();
    runUpdate("R8");

    // R9: control pins follow the synchronization clock
    waitRise();
    profSel = 2'b10; shapeEn = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9", {125'd0, profSelOut, shapeEnOut}, 128'd0);
    end
    @(negedge clk);
    check("R9", {125'd0, profSelOut, shapeEnOut}, {125'd0, 2'b10, 1'b1});

    // R10: reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    check("R10", activeRegs, 128'd0);
    check("R10", {124'd0, syncClk, xferPulse, profSelOut, shapeEnOut}, 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule